// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synthesizable single-clock synchronous SRAM that takes a new read or write command on every clock edge. Reads and writes may follow each other in any order with no idle cycles between them. Address, chip enables, write enable and byte-write masks are registered on the rising edge. The data for a write is taken two active edges later, while the write address waits in a two-stage command pipeline. Read data comes out of an output register on the second active edge after its address.

A clock-enable input turns an edge into a stall that freezes the whole pipeline. A load/advance input starts a command at a new address, or continues the previous command as a four-beat burst. In a burst the two low address bits step in linear or interleaved order, selected by a static mode pin. The output enable only gates the read-data drive flag and never disturbs the pipeline.

Top module: `zt_sram`

## Requirements
- R1: A loaded command is selected only when ce1_n=0, ce2=1 and ce3_n=0. Any other combination is a deselect, which writes nothing and never raises dq_oe.
- R2: A read captured at active edge k drives its word on dout after active edge k+2, with dq_oe=1 when oe_n=0. The word stays until the next active edge.
- R3: For a write captured at active edge k, din is sampled at active edge k+2. Lane i is din[i*LW +: LW]. Lane i is written only when bw_n[i]=0, using the bw_n value captured with the address.
- R4: A write with bw_n all ones leaves the word unchanged. For a read, bw_n has no effect.
- R5: When cen_n=1 the edge is ignored: nothing is captured, no write is performed, and dout and the read-valid state hold.
- R6: A command may be issued on every active edge in any read/write order. A read issued on the edge after a write to the same address returns the byte-merged new word.
- R7: With adv_ld_n=1 the previous command type continues and the chip enables and we_n are ignored. The upper address bits keep the loaded base. The low two bits of beat k (k=1,2,3, wrapping mod 4) are base+k when burst_linear=1 and base XOR k when burst_linear=0. An advance after a deselect stays deselected.
- R8: dq_oe is high only while a read word is held and oe_n=0. oe_n acts without a clock edge and has no effect on the pipeline.
- R9: rst_n=0 clears the command pipeline and read-valid state, so dq_oe=0. A write whose data edge had not yet come is dropped. Array contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline |
| cen_n | input | 1 | Clock enable, low = active edge, high = stall |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| adv_ld_n | input | 1 | Low = load new command, high = burst advance |
| we_n | input | 1 | Low = write, high = read (on load) |
| bw_n | input | NB | Per-lane write masks, active low |
| addr | input | AW | Word address |
| burst_linear | input | 1 | Burst order: 1 linear, 0 interleaved |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| din | input | NB*LW | Write data |
| dout | output | NB*LW | Registered read data |
| dq_oe | output | 1 | Read data drive flag |

## Verification
The hardest cases to reach are stalls that land between a write address and its data edge, and stalls in the middle of a burst. Only there does the frozen pipeline have to shift the data-sampling edge. Directed sequences place one- and two-cycle stalls right after writes and inside linear and interleaved bursts. A reset is also asserted while a write is still pending. Long random runs with frequent stalls, deselects, partial masks and bursts then mix these with read-after-write on a small address space, so that collisions are common.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;
   typedef enum logic [1:0] {
      OP_IDLE = 2'd0,
      OP_RD   = 2'd1,
      OP_WR   = 2'd2
   } zt_op_e;
endpackage

// File: rtl/zt_burst_gen.sv
module zt_burst_gen #(
   parameter int AW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   input  logic          load,
   input  logic          linear,
   input  logic [AW-1:0] addr_in,
   output logic [AW-1:0] addr_out
);
   logic [AW-1:0] base_q;
   logic [1:0]    cnt_q;
   logic [1:0]    low;

   always_comb begin
      low      = linear ? (base_q[1:0] + cnt_q) : (base_q[1:0] ^ cnt_q);
      addr_out = load ? addr_in : {base_q[AW-1:2], low};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         cnt_q  <= '0;
      end else if (adv) begin
         if (load) begin
            base_q <= addr_in;
            cnt_q  <= 2'd1;
         end else begin
            cnt_q  <= cnt_q + 2'd1;
         end
      end
   end
endmodule

// File: rtl/zt_cmd_pipe.sv
module zt_cmd_pipe
   import zt_sram_pkg::*;
#(
   parameter int AW = 6,
   parameter int NB = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   input  zt_op_e        op_in,
   input  logic [AW-1:0] addr_in,
   input  logic [NB-1:0] bw_in,
   output zt_op_e        s1_op,
   output logic [AW-1:0] s1_addr,
   output zt_op_e        s2_op,
   output logic [AW-1:0] s2_addr,
   output logic [NB-1:0] s2_bw
);
   logic [NB-1:0] s1_bw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_op   <= OP_IDLE;
         s1_addr <= '0;
         s1_bw   <= '1;
         s2_op   <= OP_IDLE;
         s2_addr <= '0;
         s2_bw   <= '1;
      end else if (adv) begin
         s1_op   <= op_in;
         s1_addr <= addr_in;
         s1_bw   <= bw_in;
         s2_op   <= s1_op;
         s2_addr <= s1_addr;
         s2_bw   <= s1_bw;
      end
   end
endmodule

// File: rtl/zt_lane_array.sv
module zt_lane_array #(
   parameter int AW = 6,
   parameter int NB = 4,
   parameter int LW = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [NB-1:0]    wr_bw_n,
   input  logic [NB*LW-1:0] wr_data,
   input  logic             rd_en,
   input  logic [AW-1:0]    rd_addr,
   output logic [NB*LW-1:0] rd_data,
   output logic             rd_vld
);
   localparam int DEPTH = 1 << AW;
   localparam int DW    = NB * LW;

   logic [DW-1:0] mem [DEPTH];
   logic [DW-1:0] old_w;
   logic [DW-1:0] new_w;

   assign old_w = mem[wr_addr];

   for (genvar g = 0; g < NB; g++) begin : g_lane
      assign new_w[g*LW +: LW] = wr_bw_n[g] ? old_w[g*LW +: LW] : wr_data[g*LW +: LW];
   end

   always_ff @(posedge clk) begin
      if (adv && wr_en) mem[wr_addr] <= new_w;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_vld  <= 1'b0;
         rd_data <= '0;
      end else if (adv) begin
         rd_vld <= rd_en;
         if (rd_en) rd_data <= mem[rd_addr];
      end
   end
endmodule

// File: rtl/zt_sram.sv
module zt_sram
   import zt_sram_pkg::*;
#(
   parameter int  AW = 6,
   parameter int  NB = 4,
   parameter int  LW = 9,
   localparam int DW = NB * LW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cen_n,
   input  logic          ce1_n,
   input  logic          ce2,
   input  logic          ce3_n,
   input  logic          adv_ld_n,
   input  logic          we_n,
   input  logic [NB-1:0] bw_n,
   input  logic [AW-1:0] addr,
   input  logic          burst_linear,
   input  logic          oe_n,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] dout,
   output logic          dq_oe
);
   if (AW < 3) begin : g_bad_aw
      $error("zt_sram: AW must be at least 3");
   end
   if (NB < 1) begin : g_bad_nb
      $error("zt_sram: NB must be at least 1");
   end
   if (LW < 1) begin : g_bad_lw
      $error("zt_sram: LW must be at least 1");
   end

   logic          adv;
   logic          load;
   logic          sel;
   zt_op_e        op_new;
   zt_op_e        s1_op;
   zt_op_e        s2_op;
   logic [AW-1:0] cmd_addr;
   logic [AW-1:0] s1_addr;
   logic [AW-1:0] s2_addr;
   logic [NB-1:0] s2_bw;
   logic          rd_vld;

   assign adv  = ~cen_n;
   assign load = ~adv_ld_n;
   assign sel  = ~ce1_n & ce2 & ~ce3_n;

   always_comb begin
      if (load) op_new = sel ? (we_n ? OP_RD : OP_WR) : OP_IDLE;
      else      op_new = s1_op;
   end

   zt_burst_gen #(.AW(AW)) u_burst (
      .clk(clk), .rst_n(rst_n), .adv(adv), .load(load),
      .linear(burst_linear), .addr_in(addr), .addr_out(cmd_addr)
   );

   zt_cmd_pipe #(.AW(AW), .NB(NB)) u_pipe (
      .clk(clk), .rst_n(rst_n), .adv(adv), .op_in(op_new),
      .addr_in(cmd_addr), .bw_in(bw_n),
      .s1_op(s1_op), .s1_addr(s1_addr),
      .s2_op(s2_op), .s2_addr(s2_addr), .s2_bw(s2_bw)
   );

   zt_lane_array #(.AW(AW), .NB(NB), .LW(LW)) u_array (
      .clk(clk), .rst_n(rst_n), .adv(adv),
      .wr_en(s2_op == OP_WR), .wr_addr(s2_addr), .wr_bw_n(s2_bw), .wr_data(din),
      .rd_en(s2_op == OP_RD), .rd_addr(s2_addr),
      .rd_data(dout), .rd_vld(rd_vld)
   );

   assign dq_oe = rd_vld & ~oe_n;
endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk
   import zt_sram_pkg::*;
#(
   parameter int AW = 6,
   parameter int DW = 36
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cen_n,
   input logic          adv_ld_n,
   input logic          ce1_n,
   input logic          ce2,
   input logic          ce3_n,
   input logic [DW-1:0] dout,
   input logic          dq_oe,
   input logic          rd_vld,
   input logic [1:0]    s1_op,
   input logic [AW-1:0] s1_addr,
   input logic [1:0]    s2_op
);
   // R1
   deselect_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cen_n && !adv_ld_n && !(!ce1_n && ce2 && !ce3_n)) |=> (s1_op == OP_IDLE));

   // R2
   read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cen_n && s2_op == OP_RD) |=> rd_vld);

   // R2
   no_spurious_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cen_n && s2_op != OP_RD) |=> !rd_vld);

   // R5
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cen_n |=> ($stable(dout) && $stable(rd_vld)));

   // R7
   burst_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cen_n && adv_ld_n && s1_op != OP_IDLE) |=> (s1_addr[AW-1:2] == $past(s1_addr[AW-1:2])));

   // R7
   burst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cen_n && adv_ld_n && s1_op != OP_IDLE) |=> (s1_addr[1:0] != $past(s1_addr[1:0])));

   // R8
   drive_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_vld |-> !dq_oe);
endmodule

bind zt_sram zt_sram_chk #(.AW(AW), .DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .adv_ld_n(adv_ld_n),
   .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .dout(dout), .dq_oe(dq_oe),
   .rd_vld(rd_vld), .s1_op(s1_op), .s1_addr(s1_addr), .s2_op(s2_op)
);

// File: tb/zt_sram_bench.sv
module zt_sram_bench;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 6;
   localparam int NB = 4;
   localparam int LW = 9;
   localparam int DW = NB * LW;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cen_n = 1'b1, ce1_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1;
   logic          adv_ld_n = 1'b0, we_n = 1'b1, burst_linear = 1'b1, oe_n = 1'b0;
   logic [NB-1:0] bw_n = '1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] dout;
   logic          dq_oe;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // bench reference model
   logic [DW-1:0] ref_mem [DEPTH];
   int            m_op1, m_op2;
   logic [AW-1:0] m_a1, m_a2, m_base;
   logic [NB-1:0] m_bw1, m_bw2;
   logic [1:0]    m_cnt;
   bit            exp_vld;
   logic [DW-1:0] exp_dout;

   zt_sram #(.AW(AW), .NB(NB), .LW(LW)) u_zt_sram (
      .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
      .adv_ld_n(adv_ld_n), .we_n(we_n), .bw_n(bw_n), .addr(addr),
      .burst_linear(burst_linear), .oe_n(oe_n), .din(din), .dout(dout), .dq_oe(dq_oe)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string tag, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: %s got %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic model_reset();
      m_op1 = 0; m_op2 = 0; m_a1 = '0; m_a2 = '0; m_bw1 = '1; m_bw2 = '1;
      m_base = '0; m_cnt = '0; exp_vld = 0;
   endtask

   // one clock: drive at negedge, model at posedge, check at next negedge
   task automatic cyc(input bit c_cen_n, input bit c_ld_n, input bit c1, input bit c2, input bit c3,
                      input bit c_we_n, input logic [NB-1:0] c_bw, input logic [AW-1:0] c_a,
                      input bit c_oe_n, input string tag);
      int            nop;
      logic [AW-1:0] na;
      logic [1:0]    low;
      logic [DW-1:0] d;
      cen_n = c_cen_n; adv_ld_n = c_ld_n; ce1_n = c1; ce2 = c2; ce3_n = c3;
      we_n = c_we_n; bw_n = c_bw; addr = c_a; oe_n = c_oe_n;
      din = {$urandom, $urandom};
      @(posedge clk);
      d = din;
      if (!c_cen_n) begin
         if (!c_ld_n) begin
            nop = (!c1 && c2 && !c3) ? (c_we_n ? 1 : 2) : 0;
            na = c_a; m_base = c_a; m_cnt = 2'd1;
         end else begin
            nop = m_op1;
            low = burst_linear ? (m_base[1:0] + m_cnt) : (m_base[1:0] ^ m_cnt);
            na = {m_base[AW-1:2], low};
            m_cnt = m_cnt + 2'd1;
         end
         exp_vld = (m_op2 == 1);
         if (m_op2 == 1) exp_dout = ref_mem[m_a2];
         if (m_op2 == 2)
            for (int i = 0; i < NB; i++)
               if (!m_bw2[i]) ref_mem[m_a2][i*LW +: LW] = d[i*LW +: LW];
         m_op2 = m_op1; m_a2 = m_a1; m_bw2 = m_bw1;
         m_op1 = nop;   m_a1 = na;   m_bw1 = c_bw;
      end
      @(negedge clk);
      chk(tag, "dq_oe", DW'(dq_oe), DW'(exp_vld && !c_oe_n));
      if (exp_vld && !c_oe_n) chk(tag, "dout", dout, exp_dout);
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [NB-1:0] m, input string tag);
      cyc(0, 0, 0, 1, 0, 0, m, a, 0, tag);
   endtask
   task automatic rd(input logic [AW-1:0] a, input string tag);
      cyc(0, 0, 0, 1, 0, 1, NB'($urandom), a, 0, tag);
   endtask
   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) cyc(0, 0, 1, 0, 1, 1, '1, '0, 0, tag);
   endtask
   task automatic advc(input string tag);
      cyc(0, 1, 1, 0, 1, 0, '0, AW'($urandom), 0, tag);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: run did not complete got %0d expected %0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      model_reset();
      @(negedge clk); @(negedge clk);
      // R9: reset state
      chk("R9", "dq_oe in reset", DW'(dq_oe), '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9", "dq_oe after reset", DW'(dq_oe), '0);

      // R3: preload every word with full masks
      for (int i = 0; i < DEPTH; i++) wr(AW'(i), '0, "R3");
      idle(2, "R3");
      for (int i = 0; i < DEPTH; i++) rd(AW'(i), "R3");
      idle(2, "R3");

      // R6: back-to-back write then read of the same word, partial mask
      wr(6'd5, 4'b1010, "R6"); rd(6'd5, "R6"); wr(6'd5, 4'b0101, "R6"); rd(6'd5, "R6");
      rd(6'd4, "R6"); wr(6'd4, 4'b0000, "R6"); rd(6'd4, "R6");
      idle(2, "R6");

      // R4: no-lane write, reads ignore masks
      wr(6'd7, 4'b1111, "R4"); rd(6'd7, "R4");
      cyc(0, 0, 0, 1, 0, 1, 4'b0000, 6'd7, 0, "R4");
      idle(2, "R4");

      // R1: every non-selecting enable combination, as write and as read
      for (int c = 0; c < 8; c++) begin
         if (c == 3'b010) continue;
         cyc(0, 0, c[2], c[1], c[0], 0, '0, 6'd9, 0, "R1");
         cyc(0, 0, c[2], c[1], c[0], 1, '0, 6'd9, 0, "R1");
      end
      idle(2, "R1");
      rd(6'd9, "R1");
      idle(2, "R1");

      // R5: stalls between write address and its data edge, and mid read
      wr(6'd10, '0, "R5");
      cyc(1, 0, 0, 1, 0, 0, '0, 6'd11, 0, "R5");
      cyc(1, 0, 0, 1, 0, 0, '0, 6'd12, 0, "R5");
      rd(6'd10, "R5");
      cyc(1, 0, 0, 1, 0, 1, '0, 6'd13, 0, "R5");
      idle(1, "R5");
      cyc(1, 1, 0, 1, 0, 1, '0, 6'd13, 0, "R5");
      idle(2, "R5");
      rd(6'd10, "R5"); rd(6'd11, "R5");
      idle(2, "R5");

      // R7: linear and interleaved bursts, stall inside, advance after deselect
      burst_linear = 1'b1;
      wr(6'd14, '0, "R7"); advc("R7");
      cyc(1, 1, 0, 1, 0, 0, '0, '0, 0, "R7");
      advc("R7"); advc("R7"); advc("R7");
      rd(6'd13, "R7"); advc("R7"); advc("R7"); advc("R7");
      idle(2, "R7");
      burst_linear = 1'b0;
      rd(6'd13, "R7"); advc("R7"); advc("R7"); advc("R7");
      wr(6'd22, 4'b0110, "R7"); advc("R7"); advc("R7");
      rd(6'd21, "R7"); advc("R7"); advc("R7"); advc("R7");
      cyc(0, 0, 1, 1, 0, 1, '0, 6'd20, 0, "R7"); advc("R7"); advc("R7");
      idle(2, "R7");

      // R8: output enable gates drive only
      rd(6'd14, "R8");
      cyc(0, 0, 0, 1, 0, 1, '0, 6'd15, 1, "R8");
      cyc(0, 0, 1, 0, 1, 1, '1, 6'd0, 1, "R8");
      cyc(0, 0, 1, 0, 1, 1, '1, 6'd0, 0, "R8");
      idle(2, "R8");

      // R9: reset drops a pending write, array kept
      wr(6'd30, '0, "R9");
      @(negedge clk);
      rst_n = 1'b0;
      model_reset();
      #1;
      chk("R9", "dq_oe during reset", DW'(dq_oe), '0);
      @(negedge clk);
      rst_n = 1'b1;
      rd(6'd30, "R9"); rd(6'd31, "R9");
      idle(2, "R9");

      // R2/R6: random mix
      for (int blk = 0; blk < 8; blk++) begin
         burst_linear = blk[0];
         rd(AW'($urandom), "R2");
         for (int i = 0; i < 400; i++) begin
            automatic int  r   = int'($urandom % 100);
            automatic bit  sc  = (r < 12);
            automatic bit  ld  = ($urandom % 4) != 0;
            automatic bit  sl  = ($urandom % 8) != 0;
            automatic logic [NB-1:0] m = (($urandom % 3) == 0) ? NB'($urandom) : '0;
            cyc(sc, !ld, !sl, 1, 0, bit'($urandom % 2), m, AW'($urandom % 16),
                ($urandom % 8) == 0, "R6");
         end
      end
      idle(3, "R2");

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule